// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block guesses where an indirect branch will jump by remembering, for each slot of a direct-mapped table, the last target that a branch mapping to that slot actually went to. The table holds one full-width target per slot. It has no tag, no per-slot valid bit and no confidence state. Two branches whose addresses select the same slot therefore share it, and each overwrites the other's target.

Each request presents a branch address together with the target the branch really resolved to. The block reports the target the table held for that slot before this request, and flags a mispredict when that stored value differs from the resolved target. The slot is then loaded with the resolved target in every case. The slot index is a field of the branch address that sits just above the instruction-alignment bits. The width of the alignment gap (0, 1 or 2 bits), the address width and the table size are all parameters.

Top module: `ind_target_pred`

## Requirements
- R1: After reset every slot reads as zero. `res_valid` and `res_mispredict` are low and `res_pred_target` is zero until the first result arrives.
- R2: The slot index is `req_branch_addr[ALIGN_SHIFT +: IDX_W]`, which is bits [10:2] with the defaults (ALIGN_SHIFT=2, IDX_W=9). Address bits outside that field do not affect which slot is used.
- R3: `res_pred_target` equals the value the indexed slot held before this request's own write.
- R4: `res_mispredict` is 1 exactly when `res_pred_target` differs from the request's `req_actual_target`.
- R5: Every accepted request writes `req_actual_target` into its slot, whether or not the prediction was correct.
- R6: A request accepted at a rising edge yields exactly one result. `res_valid` is high, in request order, in the cycle after the following rising edge (two edges of latency). No result appears without a request, and `res_mispredict` is low whenever `res_valid` is low.
- R7: Requests on consecutive cycles that hit the same slot see each other's writes: the later request predicts the earlier request's target.
- R8: While `req_valid` is low, the values on `req_branch_addr` and `req_actual_target` change no slot.
- R9: Asserting `rst` at any time returns every slot to reading zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A resolved indirect branch is presented this cycle |
| req_branch_addr | input | ADDR_W | Address of the branch instruction |
| req_actual_target | input | ADDR_W | Target the branch actually went to |
| res_valid | output | 1 | Result for the request accepted two edges earlier |
| res_pred_target | output | ADDR_W | Target stored in the slot before that request's write |
| res_mispredict | output | 1 | Stored target differed from the actual target |

## Verification
A request is accepted at one rising edge. The table read and slot write happen at that edge, and the comparison is registered at the next edge. All three result ports are therefore due two edges after acceptance. The driver stamps each expected item with its due cycle, that is, the cycle count at drive time plus two. The monitor samples on falling edges, pops an item whenever `res_valid` is seen, and checks the due cycle along with the target and the flag. Any result that arrives with nothing queued counts as an error. Back-to-back requests to the same slot, aliased addresses, idle cycles carrying garbage on the inputs, and a reset in the middle of a run each sit on this same timing.

// File: rtl/ind_tp_pkg.sv
package ind_tp_pkg;

  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_IDX_W  = 9;
  localparam int unsigned DEF_ALIGN  = 2;

  // Number of table slots for a given index width.
  function automatic int unsigned slot_count(input int unsigned idx_w);
    return 32'd1 << idx_w;
  endfunction

  // Result of one lookup before it is registered at the output.
  typedef struct packed {
    logic        hit_seen;
    logic        differs;
  } lookup_flags_t;

endpackage

// File: rtl/itp_index_sel.sv
module itp_index_sel #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned ALIGN_SHIFT = 2
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);

  // The alignment gap picks which address field selects the slot.
  generate
    if (ALIGN_SHIFT == 0) begin : g_gap0
      assign idx = addr[IDX_W-1:0];
    end else if (ALIGN_SHIFT == 1) begin : g_gap1
      assign idx = addr[IDX_W:1];
    end else begin : g_gapn
      assign idx = addr[ALIGN_SHIFT +: IDX_W];
    end
  endgenerate

endmodule

// File: rtl/itp_target_ram.sv
module itp_target_ram #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IDX_W  = 9
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);

  localparam int unsigned DEPTH = ind_tp_pkg::slot_count(IDX_W);

  logic [DATA_W-1:0] mem [DEPTH];

  // Read-first single port: the read returns the contents from before the
  // write performed at the same edge.
  always_ff @(posedge clk) begin
    if (en) begin
      rdata    <= mem[idx];
      mem[idx] <= wdata;
    end
  end

endmodule

// File: rtl/itp_seen_map.sv
module itp_seen_map #(
  parameter int unsigned IDX_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [IDX_W-1:0] idx,
  output logic             seen_q
);

  localparam int unsigned DEPTH = ind_tp_pkg::slot_count(IDX_W);

  // One flop per slot marks that the RAM word has been written since reset.
  // Slots not yet written are reported as zero.
  logic [DEPTH-1:0] seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen   <= '0;
      seen_q <= 1'b0;
    end else if (en) begin
      seen_q    <= seen[idx];
      seen[idx] <= 1'b1;
    end
  end

endmodule

// File: rtl/itp_resolve_stage.sv
module itp_resolve_stage #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s1_valid,
  input  logic              s1_seen,
  input  logic [ADDR_W-1:0] s1_raw,
  input  logic [ADDR_W-1:0] s1_actual,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_pred_target,
  output logic              res_mispredict
);

  logic [ADDR_W-1:0]         pred_c;
  ind_tp_pkg::lookup_flags_t flags_c;

  always_comb begin
    pred_c           = s1_seen ? s1_raw : '0;
    flags_c.hit_seen = s1_seen;
    flags_c.differs  = (pred_c != s1_actual);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_valid       <= 1'b0;
      res_pred_target <= '0;
      res_mispredict  <= 1'b0;
    end else begin
      res_valid <= s1_valid;
      if (s1_valid) begin
        res_pred_target <= pred_c;
        res_mispredict  <= flags_c.differs;
      end else begin
        res_mispredict  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ind_target_pred.sv
module ind_target_pred #(
  parameter int unsigned ADDR_W      = ind_tp_pkg::DEF_ADDR_W,
  parameter int unsigned IDX_W       = ind_tp_pkg::DEF_IDX_W,
  parameter int unsigned ALIGN_SHIFT = ind_tp_pkg::DEF_ALIGN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_branch_addr,
  input  logic [ADDR_W-1:0] req_actual_target,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_pred_target,
  output logic              res_mispredict
);

  logic [IDX_W-1:0]  slot_idx;
  logic              acc;
  logic              s1_valid;
  logic              s1_seen;
  logic [ADDR_W-1:0] s1_raw;
  logic [ADDR_W-1:0] s1_actual;

  assign acc = req_valid && !rst;

  itp_index_sel #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .ALIGN_SHIFT(ALIGN_SHIFT)
  ) idx_i (
    .addr(req_branch_addr),
    .idx (slot_idx)
  );

  itp_target_ram #(
    .DATA_W(ADDR_W),
    .IDX_W (IDX_W)
  ) ram_i (
    .clk  (clk),
    .en   (acc),
    .idx  (slot_idx),
    .wdata(req_actual_target),
    .rdata(s1_raw)
  );

  itp_seen_map #(
    .IDX_W(IDX_W)
  ) seen_i (
    .clk   (clk),
    .rst   (rst),
    .en    (acc),
    .idx   (slot_idx),
    .seen_q(s1_seen)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid  <= 1'b0;
      s1_actual <= '0;
    end else begin
      s1_valid <= req_valid;
      if (req_valid) s1_actual <= req_actual_target;
    end
  end

  itp_resolve_stage #(
    .ADDR_W(ADDR_W)
  ) res_i (
    .clk            (clk),
    .rst            (rst),
    .s1_valid       (s1_valid),
    .s1_seen        (s1_seen),
    .s1_raw         (s1_raw),
    .s1_actual      (s1_actual),
    .res_valid      (res_valid),
    .res_pred_target(res_pred_target),
    .res_mispredict (res_mispredict)
  );

endmodule

// File: rtl/itp_checker.sv
module itp_checker #(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned IDX_W       = 9,
  parameter int unsigned ALIGN_SHIFT = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_branch_addr,
  input logic [ADDR_W-1:0] req_actual_target,
  input logic              res_valid,
  input logic [ADDR_W-1:0] res_pred_target,
  input logic              res_mispredict
);

  logic              v1, v2, v3;
  logic [IDX_W-1:0]  i1, i2, i3;
  logic [ADDR_W-1:0] a1, a2, a3;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0; v2 <= 1'b0; v3 <= 1'b0;
      i1 <= '0;   i2 <= '0;   i3 <= '0;
      a1 <= '0;   a2 <= '0;   a3 <= '0;
    end else begin
      v1 <= req_valid;
      i1 <= req_branch_addr[ALIGN_SHIFT +: IDX_W];
      a1 <= req_actual_target;
      v2 <= v1; i2 <= i1; a2 <= a1;
      v3 <= v2; i3 <= i2; a3 <= a2;
    end
  end

  AST_RES_TIMING: assert property (@(posedge clk) disable iff (rst)
    res_valid == v2); // R6

  AST_MISP_MATCH: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_mispredict == (res_pred_target != a2))); // R4

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> !res_mispredict); // R6

  AST_B2B_SAME_SLOT: assert property (@(posedge clk) disable iff (rst)
    (res_valid && v3 && (i2 == i3)) |-> (res_pred_target == a3)); // R7

endmodule

bind ind_target_pred itp_checker #(
  .ADDR_W     (ADDR_W),
  .IDX_W      (IDX_W),
  .ALIGN_SHIFT(ALIGN_SHIFT)
) chk_i (
  .clk              (clk),
  .rst              (rst),
  .req_valid        (req_valid),
  .req_branch_addr  (req_branch_addr),
  .req_actual_target(req_actual_target),
  .res_valid        (res_valid),
  .res_pred_target  (res_pred_target),
  .res_mispredict   (res_mispredict)
);

// File: tb/ind_target_pred_tb_top.sv
module ind_target_pred_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW    = 32;
  localparam int IW    = 9;
  localparam int ALIGN = 2;
  localparam int WD_CYCLES = 20000;

  typedef struct {
    logic [AW-1:0] pred;
    logic          misp;
    longint        due;
    string         rq;
  } exp_t;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_branch_addr = '0;
  logic [AW-1:0] req_actual_target = '0;
  logic          res_valid;
  logic [AW-1:0] res_pred_target;
  logic          res_mispredict;

  int     n_checks = 0;
  int     n_fail   = 0;
  longint cyc      = 0;
  logic [AW-1:0] mdl [1 << IW];
  exp_t   sbq [$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ind_target_pred #(.ADDR_W(AW), .IDX_W(IW), .ALIGN_SHIFT(ALIGN)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .req_branch_addr(req_branch_addr), .req_actual_target(req_actual_target),
    .res_valid(res_valid), .res_pred_target(res_pred_target),
    .res_mispredict(res_mispredict)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", rq, what, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int k = 0; k < (1 << IW); k++) mdl[k] = '0;
  endtask

  task automatic send(input logic [AW-1:0] a, input logic [AW-1:0] t, input string rq);
    exp_t e;
    int   ix;
    @(negedge clk);
    ix     = int'((a >> ALIGN) & ((1 << IW) - 1));
    e.pred = mdl[ix];
    e.misp = (mdl[ix] != t);
    e.due  = cyc + 2;
    e.rq   = rq;
    mdl[ix] = t;
    sbq.push_back(e);
    req_valid         = 1'b1;
    req_branch_addr   = a;
    req_actual_target = t;
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // Monitor: pop and compare each result as it appears.
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        if (sbq.size() == 0) begin
          chk(1'b0, "R6", "result with nothing queued", 1, 0);
        end else begin
          exp_t e;
          e = sbq.pop_front();
          chk(cyc == e.due, "R6", "result cycle", AW'(cyc), AW'(e.due));
          chk(res_pred_target == e.pred, e.rq, "pred_target", res_pred_target, e.pred);
          chk(res_mispredict == e.misp, e.rq, "mispredict", AW'(res_mispredict), AW'(e.misp));
        end
      end else if (res_mispredict) begin
        chk(1'b0, "R6", "mispredict while idle", 1, 0);
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    chk(1'b0, "R6", "watchdog expired", AW'(cyc), 0);
    finish_run();
  end

  initial begin
    logic [31:0] lcg;
    logic [AW-1:0] base;
    clear_model();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state of outputs
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(!res_valid && !res_mispredict && res_pred_target == '0, "R1",
          "reset outputs", {res_valid, res_mispredict, res_pred_target[29:0]}, 0);
    end

    // R1: fresh slots read zero
    send(32'h0000_0014, 32'h1234_5678, "R1");
    send(32'h0000_0100, 32'h0000_0000, "R1");
    idle(2);
    // R3/R4: same target again, no mispredict
    send(32'h0000_0014, 32'h1234_5678, "R3");
    idle(1);
    // R5: change target, then see it stored
    send(32'h0000_0014, 32'hCAFE_0000, "R5");
    idle(2);
    send(32'h0000_0014, 32'hCAFE_0000, "R5");
    idle(1);
    // R2: aliasing above the field and within the alignment bits
    base = 32'h0000_0040;
    send(base, 32'hAAAA_0001, "R2");
    idle(1);
    send(base + (32'd1 << (ALIGN + IW)), 32'hAAAA_0002, "R2");
    send(base + 32'd3, 32'hAAAA_0003, "R2");
    send(base + (32'd1 << ALIGN), 32'hAAAA_0004, "R2");
    send(base + 32'h7FF0_0000, 32'hAAAA_0003, "R2");
    idle(2);
    // R7: consecutive same-slot requests
    send(32'h0000_0200, 32'h0000_1111, "R7");
    send(32'h0000_0200, 32'h0000_2222, "R7");
    send(32'h0000_0200, 32'h0000_2222, "R7");
    send(32'h8000_0200, 32'h0000_3333, "R7");
    idle(3);
    // R3/R5: back-to-back stream on a few slots
    lcg = 32'h1357_9BDF;
    for (int k = 0; k < 48; k++) begin
      lcg = lcg * 32'd1664525 + 32'd1013904223;
      send({lcg[31:24], 19'd0, lcg[2:0], 2'b00}, {28'h0F0_0000, lcg[13:12], 2'b00},
           "R3");
      if (lcg[20]) idle(1);
    end
    idle(3);
    // R8: idle cycles with garbage on the inputs
    send(32'h0000_0300, 32'h5555_AAAA, "R8");
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      req_valid         = 1'b0;
      req_branch_addr   = 32'h0000_0300;
      req_actual_target = 32'hDEAD_0000 + k;
    end
    send(32'h0000_0300, 32'h5555_AAAA, "R8");
    idle(4);
    // R9: reset mid-run clears every slot
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    clear_model();
    rst = 1'b0;
    @(negedge clk);
    chk(!res_valid, "R9", "res_valid after reset", AW'(res_valid), 0);
    send(32'h0000_0014, 32'h1234_5678, "R9");
    send(32'h0000_0300, 32'h0000_0000, "R9");
    idle(4);
    chk(sbq.size() == 0, "R6", "results outstanding", AW'(sbq.size()), 0);
    finish_run();
  end

endmodule